// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a peripheral clock into the 16x oversampling strobe that a UART's transmitter and receiver sample on. A 16-bit integer divisor is assembled from two byte-wide inputs. A fractional prescale, given as an addend A and a multiplier M, stretches the integer period. The average strobe period becomes D × (1 + A/M) clock cycles, where D is the combined divisor. This lets a fixed peripheral clock reach standard baud rates with small error.

The fraction is realised by an accumulator. At the end of each integer period, A is added to it. When the sum reaches M, M is subtracted and the strobe is held back by one extra integer period. Any change on the divisor or fraction inputs restarts the divider and clears the accumulator on the following clock edge. A configuration whose fraction cannot be realised raises an error flag, and the block then falls back to the plain integer divider.

Top module: `frac_baud_gen`

## Requirements
- R1: The divisor is D = 256 × div_hi + div_lo, with div_hi as the upper byte. With A = 0, os_tick is high for one cycle once every D cycles.
- R2: A combined divisor of 0 behaves as D = 1, so with A = 0 os_tick is high on every cycle.
- R3: The fraction input is encoded as frac_cfg[3:0] = A and frac_cfg[7:4] = M − 1. For a legal setting with A ≠ 0, every gap between ticks is D or 2D cycles. A tick and the M-th tick after it are exactly D × (M + A) cycles apart.
- R4: With div_hi = 0, div_lo = 4, A = 5 and M = 8 (field value 7), the average tick period is 6.5 cycles. At a 12 MHz clock this gives about 115384 baud, within 1 % of that figure and within 0.2 % of 115200.
- R5: cfg_err is high one cycle after frac_cfg shows A ≥ M or a field value of 15 in frac_cfg[7:4]. While it is high, the fraction is bypassed and every gap is exactly D cycles.
- R6: While en is low, os_tick stays low from the next edge onward. After en returns high, the first tick follows the rising edge D cycles after the first edge that samples en high.
- R7: A change on div_hi, div_lo or frac_cfg clears the counter and the accumulator at the edge that samples the new value. os_tick is low in the following cycle, and the first tick follows the edge D + 1 cycles after that edge.
- R8: Synchronous active-high reset drives os_tick and cfg_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the divider cleared |
| div_hi | input | 8 | Upper byte of the integer divisor |
| div_lo | input | 8 | Lower byte of the integer divisor |
| frac_cfg | input | 8 | [3:0] fraction addend A, [7:4] multiplier M minus one |
| os_tick | output | 1 | One-cycle 16x oversampling strobe |
| cfg_err | output | 1 | Fraction setting cannot be realised |

## Verification
A corrupted accumulator shows at the ports within M ticks: the span from one tick to the M-th following one differs from D × (M + A). Measuring that span at every starting tick catches such faults, as well as a stretch that is missed or doubled. A counter that fails to clear on restart or enable moves the first tick away from its fixed edge, so that edge is checked exactly. A wrong legality decision shows on cfg_err one cycle after the input changes, and it also shows as gaps that are all D when they should mix D and 2D, or the reverse.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic {
    PH_RUN     = 1'b0,
    PH_STRETCH = 1'b1
  } fbg_phase_e;

  // A fraction is unusable when the addend is not below the multiplier
  // or when the multiplier field holds its top code.
  function automatic logic frac_illegal(input int unsigned add_v,
                                        input int unsigned mul_m1,
                                        input int unsigned field_top);
    return (mul_m1 >= field_top) || (add_v >= mul_m1 + 1);
  endfunction

endpackage

// File: rtl/fbg_cfg_track.sv
module fbg_cfg_track #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 4,
  localparam int DIV_W  = 2 * BYTE_W,
  localparam int FRAC_W = 2 * FIELD_W,
  localparam int MUL_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  div_hi,
  input  logic [BYTE_W-1:0]  div_lo,
  input  logic [FRAC_W-1:0]  frac_in,
  output logic               restart,
  output logic [DIV_W-1:0]   div_q,
  output logic [FIELD_W-1:0] add_q,
  output logic [MUL_W-1:0]   mul_q,
  output logic               frac_on_q,
  output logic               err_q
);
  localparam int unsigned      FIELD_TOP = (1 << FIELD_W) - 1;
  localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);
  localparam logic [MUL_W-1:0] MUL_ONE   = MUL_W'(1);

  logic [BYTE_W-1:0]  hi_q;
  logic [BYTE_W-1:0]  lo_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [DIV_W-1:0]   div_raw;
  logic [FIELD_W-1:0] add_in;
  logic [FIELD_W-1:0] mulm1_in;
  logic               illegal_in;

  assign div_raw    = {div_hi, div_lo};
  assign add_in     = frac_in[FIELD_W-1:0];
  assign mulm1_in   = frac_in[FRAC_W-1:FIELD_W];
  assign illegal_in = fbg_pkg::frac_illegal(32'(add_in), 32'(mulm1_in), FIELD_TOP);

  // Any difference from the held copy restarts the divider at this edge.
  assign restart = (div_hi != hi_q) || (div_lo != lo_q) || (frac_in != frac_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      frac_q    <= '0;
      div_q     <= DIV_ONE;
      add_q     <= '0;
      mul_q     <= MUL_ONE;
      frac_on_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      hi_q      <= div_hi;
      lo_q      <= div_lo;
      frac_q    <= frac_in;
      div_q     <= (div_raw == '0) ? DIV_ONE : div_raw;
      add_q     <= add_in;
      mul_q     <= {1'b0, mulm1_in} + MUL_ONE;
      frac_on_q <= !illegal_in && (add_in != '0);
      err_q     <= illegal_in;
    end
  end

endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             period_end
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt_q      <= '0;
      period_end <= 1'b0;
    end else if (cnt_q >= div - DIV_ONE) begin
      cnt_q      <= '0;
      period_end <= 1'b1;
    end else begin
      cnt_q      <= cnt_q + DIV_ONE;
      period_end <= 1'b0;
    end
  end

endmodule

// File: rtl/fbg_frac_stage.sv
module fbg_frac_stage #(
  parameter int FIELD_W = 4,
  localparam int MUL_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               restart,
  input  logic               period_end,
  input  logic               frac_on,
  input  logic [FIELD_W-1:0] add,
  input  logic [MUL_W-1:0]   mul,
  output logic               tick
);
  import fbg_pkg::*;

  fbg_phase_e       phase_q;
  logic [MUL_W-1:0] acc_q;
  logic [MUL_W-1:0] sum;

  assign sum = acc_q + {1'b0, add};

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      acc_q   <= '0;
      phase_q <= PH_RUN;
      tick    <= 1'b0;
    end else if (period_end) begin
      if (phase_q == PH_STRETCH) begin
        phase_q <= PH_RUN;
        tick    <= 1'b1;
      end else if (frac_on && (sum >= mul)) begin
        acc_q   <= sum - mul;
        phase_q <= PH_STRETCH;
        tick    <= 1'b0;
      end else begin
        acc_q   <= frac_on ? sum : '0;
        tick    <= 1'b1;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 4,
  localparam int FRAC_W = 2 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [FRAC_W-1:0] frac_cfg,
  output logic              os_tick,
  output logic              cfg_err
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int MUL_W = FIELD_W + 1;

  logic               restart_w;
  logic [DIV_W-1:0]   div_w;
  logic [FIELD_W-1:0] add_w;
  logic [MUL_W-1:0]   mul_w;
  logic               frac_on_w;
  logic               pend_w;

  fbg_cfg_track #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .frac_in   (frac_cfg),
    .restart   (restart_w),
    .div_q     (div_w),
    .add_q     (add_w),
    .mul_q     (mul_w),
    .frac_on_q (frac_on_w),
    .err_q     (cfg_err)
  );

  fbg_int_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .restart    (restart_w),
    .div        (div_w),
    .period_end (pend_w)
  );

  fbg_frac_stage #(.FIELD_W(FIELD_W)) u_frac (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .restart    (restart_w),
    .period_end (pend_w),
    .frac_on    (frac_on_w),
    .add        (add_w),
    .mul        (mul_w),
    .tick       (os_tick)
  );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 4,
  localparam int FRAC_W = 2 * FIELD_W,
  localparam int DIV_W  = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [FRAC_W-1:0] frac_cfg,
  input logic              os_tick,
  input logic              cfg_err,
  input logic              restart,
  input logic              frac_on,
  input logic [DIV_W-1:0]  div_cur
);
  logic [FIELD_W-1:0] a_in;
  logic [FIELD_W-1:0] m_field;
  logic               bad_in;

  assign a_in    = frac_cfg[FIELD_W-1:0];
  assign m_field = frac_cfg[FRAC_W-1:FIELD_W];
  assign bad_in  = (a_in > m_field) || (&m_field);

  // R1: with a divisor above one, a strobe never lasts two cycles
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (os_tick && (div_cur != DIV_W'(1))) |=> !os_tick);

  // R5: error flag follows the fraction input one cycle later
  p_err_latency_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == $past(bad_in)));

  // R5: an unusable fraction never drives the stretch logic
  p_err_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !frac_on);

  // R6: disabled generator stays silent
  p_quiet_off_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !os_tick);

  // R7: a restart edge is followed by a quiet cycle
  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> !os_tick);

  // R8: reset leaves both outputs low
  p_reset_low_r8: assert property (@(posedge clk)
    rst |=> (!os_tick && !cfg_err));

endmodule

bind frac_baud_gen fbg_checker #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .frac_cfg (frac_cfg),
  .os_tick  (os_tick),
  .cfg_err  (cfg_err),
  .restart  (restart_w),
  .frac_on  (frac_on_w),
  .div_cur  (div_w)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] div_hi = '0;
  logic [7:0] div_lo = '0;
  logic [7:0] frac_cfg = '0;
  logic       os_tick;
  logic       cfg_err;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ts[2048];
  int nts = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen uut (
    .clk(clk), .rst(rst), .en(en), .div_hi(div_hi), .div_lo(div_lo),
    .frac_cfg(frac_cfg), .os_tick(os_tick), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input int a, input int mf);
    @(negedge clk);
    div_hi   = d[15:8];
    div_lo   = d[7:0];
    frac_cfg = {mf[3:0], a[3:0]};
  endtask

  task automatic collect(input int n, input int maxc);
    nts = 0;
    for (int k = 0; k < maxc && nts < n; k++) begin
      @(negedge clk);
      if (os_tick) begin
        ts[nts] = cyc;
        nts++;
      end
    end
  endtask

  task automatic verify(input string req, input int d, input int a, input int m, input bit stretch);
    int dd;
    int bad_gap;
    int bad_win;
    dd = (d == 0) ? 1 : d;
    bad_gap = 0;
    bad_win = 0;
    for (int i = 0; i + 1 < nts; i++) begin
      int g;
      g = ts[i+1] - ts[i];
      if (!(g == dd || (stretch && g == 2 * dd))) bad_gap++;
    end
    check(bad_gap == 0, {req, " gap"}, bad_gap, 0);
    if (stretch) begin
      for (int i = 0; i + m < nts; i++)
        if (ts[i+m] - ts[i] != dd * (m + a)) bad_win++;
      check(bad_win == 0, {req, " window"}, bad_win, 0);
    end
  endtask

  task automatic run_case(input string req, input int d, input int a, input int mf, input int n);
    int dd;
    bit legal;
    dd = (d == 0) ? 1 : d;
    legal = (a <= mf) && (mf != 15);
    set_cfg(d, a, mf);
    @(negedge clk);
    check(cfg_err == !legal, {req, " err flag"}, int'(cfg_err), int'(!legal));
    @(negedge clk);
    collect(n, n * 2 * dd + 4 * dd + 20);
    check(nts == n, {req, " tick count"}, nts, n);
    verify(req, d, a, mf + 1, legal && (a != 0));
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    int c;
    int first;
    int quiet;
    real avg;
    real baud;
    void'($urandom(32'd24681));

    // R8 reset state
    repeat (4) @(negedge clk);
    check(!os_tick && !cfg_err, "R8 in reset", int'(os_tick) + int'(cfg_err), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!os_tick && !cfg_err, "R8 after reset", int'(os_tick) + int'(cfg_err), 0);
    en = 1'b1;

    // R4 example setting
    set_cfg(4, 5, 7);
    repeat (3) @(negedge clk);
    collect(801, 8000);
    check(nts == 801, "R4 tick count", nts, 801);
    verify("R4", 4, 5, 8, 1'b1);
    if (nts == 801) begin
      avg  = real'(ts[800] - ts[0]) / 800.0;
      baud = 12.0e6 / (16.0 * avg);
      check(avg == 6.5, "R4 average period x100", int'(avg * 100.0), 650);
      check((baud > 115384.0 * 0.99) && (baud < 115384.0 * 1.01), "R4 baud", int'(baud), 115384);
      check((baud - 115200.0) / 115200.0 < 0.002 && baud > 115200.0, "R4 error vs 115200", int'(baud), 115200);
    end

    // R1 plain integer division, including the upper byte
    run_case("R1", 7, 0, 0, 40);
    run_case("R1", 258, 0, 3, 8);

    // R2 zero divisor
    run_case("R2", 0, 0, 0, 50);
    run_case("R2", 0, 1, 1, 30);

    // R3 fractional stretch
    run_case("R3", 300, 3, 6, 15);
    run_case("R3", 9, 14, 14, 40);

    // R5 unusable fractions and a legal neighbour
    run_case("R5", 6, 6, 5, 20);
    run_case("R5", 5, 3, 15, 20);
    run_case("R5", 5, 2, 4, 20);

    // R7 restart timing on divisor change
    set_cfg(5, 0, 0);
    c = cyc;
    @(negedge clk);
    check(!os_tick, "R7 quiet after change", int'(os_tick), 0);
    first = -1;
    for (int k = 0; k < 40 && first < 0; k++) begin
      @(negedge clk);
      if (os_tick) first = cyc;
    end
    check(first == c + 7, "R7 first tick after divisor change", first - c, 7);

    // R7 restart timing on fraction-only change
    set_cfg(5, 1, 2);
    c = cyc;
    first = -1;
    for (int k = 0; k < 40 && first < 0; k++) begin
      @(negedge clk);
      if (os_tick) first = cyc;
    end
    check(first == c + 7, "R7 first tick after fraction change", first - c, 7);

    // R6 disable and re-enable
    set_cfg(5, 0, 0);
    repeat (10) @(negedge clk);
    en = 1'b0;
    quiet = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (os_tick) quiet++;
    end
    check(quiet == 0, "R6 ticks while disabled", quiet, 0);
    en = 1'b1;
    c = cyc;
    first = -1;
    for (int k = 0; k < 40 && first < 0; k++) begin
      @(negedge clk);
      if (os_tick) first = cyc;
    end
    check(first == c + 6, "R6 first tick after enable", first - c, 6);

    // R3 random legal settings
    for (int it = 0; it < 12; it++) begin
      int d;
      int mf;
      int a;
      d  = 1 + int'($urandom % 24);
      mf = int'($urandom % 15);
      a  = int'($urandom % (mf + 1));
      run_case("R3 random", d, a, mf, 3 * (mf + 1) + 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule